// File: doc/BRIEF.md
# Shadow Return Address Stack

This block guards procedure returns in a processor pipeline. Every call hands the block the return address it has also written to the program stack, and the block keeps its own copy in private storage. Ordinary loads and stores have no path to that storage. Every return presents the address the program reloaded from its stack. The block pops its copy and supplies that copy as the return target. If the two addresses differ, it raises a violation.

The private storage holds a fixed number of entries. When a call arrives with the storage full, the oldest entry is written out through a narrow memory port into an overflow region. Only privileged software may map that region. A later return that finds the private storage empty, with entries still out in that region, stalls while one entry is read back. A return with nothing saved anywhere is reported as an underflow.

Top module: `shadow_ret_stack`

## Requirements
- R1: After reset, `ret_ready` is high while no call is presented, `ret_target` is 0, `viol_pulse`, `under_pulse`, `spill_wr_en` and `spill_rd_req` are low, and `viol_count` is 0.
- R2: Return addresses come only from `call_addr`. Accepted returns receive them in last-in first-out order on `ret_target`, and `ret_addr` is never stored.
- R3: An accepted return whose `ret_addr` equals the saved copy produces no `viol_pulse`.
- R4: An accepted return whose `ret_addr` differs from the saved copy still gets the saved copy on `ret_target`. `viol_pulse` is high for exactly the one cycle after acceptance, and `viol_count` rises by one on the same edge.
- R5: `viol_count` saturates at 2^CNT_W-1 and never decreases outside reset.
- R6: A call arriving while DEPTH entries are held drives `spill_wr_en` in that same cycle. `spill_wr_data` carries the oldest held entry and `spill_addr` carries the number of entries already spilled (0 for the first). The new address is still pushed.
- R7: A return that arrives with the private storage empty and N>0 entries spilled keeps `ret_ready` low. It raises `spill_rd_req` for one cycle with `spill_addr` = N-1, loads `spill_rd_data` on the cycle `spill_rd_valid` is high, and accepts the return on a following cycle with that value as target.
- R8: A return that arrives with nothing held or spilled is accepted with `ret_target` 0. `under_pulse` is high in the next cycle, and `viol_count` is left unchanged.
- R9: When a call and a return are presented in the same cycle, the call is taken and `ret_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_valid | input | 1 | A call is retiring this cycle |
| call_addr | input | AW | Return address of that call |
| ret_valid | input | 1 | A return is presented |
| ret_addr | input | AW | Address reloaded from the program stack |
| ret_ready | output | 1 | The presented return is accepted this cycle |
| ret_target | output | AW | Saved return address to branch to |
| viol_pulse | output | 1 | One-cycle mismatch indication |
| under_pulse | output | 1 | One-cycle underflow indication |
| viol_count | output | CNT_W | Saturating mismatch count |
| spill_wr_en | output | 1 | Write oldest entry to overflow region |
| spill_rd_req | output | 1 | Request one entry back from overflow region |
| spill_addr | output | SPILL_W | Entry index in overflow region |
| spill_wr_data | output | AW | Entry being spilled |
| spill_rd_valid | input | 1 | Requested entry is on `spill_rd_data` |
| spill_rd_data | input | AW | Entry returned from overflow region |

## Verification
A corrupted stack pointer or base index does not stay hidden. The next accepted return shows a wrong `ret_target` in the same cycle and a spurious `viol_pulse` one cycle later. A wrong spill count shows the next time the storage overflows or drains: it puts the wrong index on `spill_addr`, or starts a read-back when none is due, or skips one that is needed. For that reason the bench pushes past the capacity and drains every entry back, comparing each target and each spill index. A counter fault shows directly on `viol_count` after the first mismatch or at saturation.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic {
    SRS_RUN  = 1'b0,
    SRS_FILL = 1'b1
  } srs_state_e;
endpackage

// File: rtl/srs_store.sv
// Private circular storage of return addresses; full push overwrites the oldest slot.
module srs_store #(
  parameter int AW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_data,
  input  logic          pop,
  input  logic          fill,
  input  logic [AW-1:0] fill_data,
  output logic [AW-1:0] top_data,
  output logic [AW-1:0] old_data,
  output logic          full,
  output logic          empty
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] mem [DEPTH];
  logic [IW-1:0] bot_q, bot_d, top_idx, wr_idx, cnt_lo;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_en;
  logic [AW-1:0] wr_data;

  assign cnt_lo   = cnt_q[IW-1:0];
  assign full     = (cnt_q == CW'(DEPTH));
  assign empty    = (cnt_q == '0);
  assign top_idx  = bot_q + cnt_lo - IW'(1);
  assign top_data = mem[top_idx];
  assign old_data = mem[bot_q];

  always_comb begin
    bot_d   = bot_q;
    cnt_d   = cnt_q;
    wr_en   = 1'b0;
    wr_idx  = bot_q;
    wr_data = push_data;
    if (push) begin
      wr_en = 1'b1;
      if (full) begin
        wr_idx = bot_q;
        bot_d  = bot_q + IW'(1);
      end else begin
        wr_idx = bot_q + cnt_lo;
        cnt_d  = cnt_q + CW'(1);
      end
    end else if (fill) begin
      wr_en   = 1'b1;
      wr_idx  = bot_q;
      wr_data = fill_data;
      cnt_d   = CW'(1);
    end else if (pop) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bot_q <= '0;
      cnt_q <= '0;
    end else begin
      bot_q <= bot_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end
endmodule

// File: rtl/srs_ctrl.sv
// Sequencing of calls, returns, spills and refills.
module srs_ctrl #(
  parameter int SPILL_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               call_valid,
  input  logic               ret_valid,
  input  logic               full,
  input  logic               empty,
  input  logic               spill_rd_valid,
  output logic               ret_ready,
  output logic               push,
  output logic               pop,
  output logic               fill,
  output logic               none,
  output logic               spill_wr_en,
  output logic               spill_rd_req,
  output logic [SPILL_W-1:0] spill_addr
);
  import srs_pkg::*;

  srs_state_e         st_q, st_d;
  logic [SPILL_W-1:0] nsp_q, nsp_d;
  logic               run, acc, have_spill;

  assign run          = (st_q == SRS_RUN);
  assign have_spill   = (nsp_q != '0);
  assign ret_ready    = run && !call_valid && (!empty || !have_spill);
  assign acc          = ret_valid && ret_ready;
  assign pop          = acc && !empty;
  assign none         = acc && empty;
  assign push         = run && call_valid;
  assign spill_wr_en  = push && full;
  assign spill_rd_req = run && ret_valid && !call_valid && empty && have_spill;
  assign fill         = !run && spill_rd_valid;
  assign spill_addr   = spill_wr_en ? nsp_q : nsp_q - SPILL_W'(1);

  always_comb begin
    st_d  = st_q;
    nsp_d = nsp_q;
    if (spill_wr_en) nsp_d = nsp_q + SPILL_W'(1);
    if (spill_rd_req) st_d = SRS_FILL;
    if (fill) begin
      st_d  = SRS_RUN;
      nsp_d = nsp_q - SPILL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SRS_RUN;
      nsp_q <= '0;
    end else begin
      st_q  <= st_d;
      nsp_q <= nsp_d;
    end
  end
endmodule

// File: rtl/srs_guard.sv
// Compares the claimed return address with the saved copy and keeps the violation record.
module srs_guard #(
  parameter int AW    = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             none,
  input  logic [AW-1:0]    saved,
  input  logic [AW-1:0]    claimed,
  output logic             viol_pulse,
  output logic             under_pulse,
  output logic [CNT_W-1:0] viol_count
);
  logic             bad, vp_d, up_d;
  logic [CNT_W-1:0] cnt_d;

  assign bad = take && (saved != claimed);

  always_comb begin
    vp_d  = bad;
    up_d  = none;
    cnt_d = viol_count;
    if (bad && (viol_count != '1)) cnt_d = viol_count + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_pulse  <= 1'b0;
      under_pulse <= 1'b0;
      viol_count  <= '0;
    end else begin
      viol_pulse  <= vp_d;
      under_pulse <= up_d;
      viol_count  <= cnt_d;
    end
  end
endmodule

// File: rtl/shadow_ret_stack.sv
module shadow_ret_stack #(
  parameter int AW      = 32,
  parameter int DEPTH   = 16,
  parameter int CNT_W   = 8,
  parameter int SPILL_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               call_valid,
  input  logic [AW-1:0]      call_addr,
  input  logic               ret_valid,
  input  logic [AW-1:0]      ret_addr,
  output logic               ret_ready,
  output logic [AW-1:0]      ret_target,
  output logic               viol_pulse,
  output logic               under_pulse,
  output logic [CNT_W-1:0]   viol_count,
  output logic               spill_wr_en,
  output logic               spill_rd_req,
  output logic [SPILL_W-1:0] spill_addr,
  output logic [AW-1:0]      spill_wr_data,
  input  logic               spill_rd_valid,
  input  logic [AW-1:0]      spill_rd_data
);
  logic          push, pop, fill, none, full, empty;
  logic [AW-1:0] top_data;

  srs_store #(.AW(AW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(call_addr),
    .pop(pop), .fill(fill), .fill_data(spill_rd_data),
    .top_data(top_data), .old_data(spill_wr_data), .full(full), .empty(empty)
  );

  srs_ctrl #(.SPILL_W(SPILL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .call_valid(call_valid), .ret_valid(ret_valid),
    .full(full), .empty(empty), .spill_rd_valid(spill_rd_valid),
    .ret_ready(ret_ready), .push(push), .pop(pop), .fill(fill), .none(none),
    .spill_wr_en(spill_wr_en), .spill_rd_req(spill_rd_req), .spill_addr(spill_addr)
  );

  assign ret_target = empty ? '0 : top_data;

  srs_guard #(.AW(AW), .CNT_W(CNT_W)) u_guard (
    .clk(clk), .rst_n(rst_n), .take(pop), .none(none),
    .saved(top_data), .claimed(ret_addr),
    .viol_pulse(viol_pulse), .under_pulse(under_pulse), .viol_count(viol_count)
  );
endmodule

// File: rtl/srs_chk.sv
module srs_chk #(
  parameter int AW    = 32,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             call_valid,
  input logic             ret_valid,
  input logic [AW-1:0]    ret_addr,
  input logic             ret_ready,
  input logic [AW-1:0]    ret_target,
  input logic             viol_pulse,
  input logic             under_pulse,
  input logic [CNT_W-1:0] viol_count,
  input logic             spill_wr_en,
  input logic             spill_rd_req
);
  // R4
  viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> $past(ret_valid && ret_ready && (ret_addr != ret_target)));
  // R5
  count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_count >= $past(viol_count));
  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_count != $past(viol_count)) |-> viol_pulse);
  // R8
  under_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    under_pulse |-> (!viol_pulse && $past(ret_valid && ret_ready)));
  // R6
  spill_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spill_wr_en |-> (call_valid && !spill_rd_req));
  // R7
  refill_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spill_rd_req |=> !ret_ready);
  // R9
  call_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_valid |-> !ret_ready);
endmodule

bind shadow_ret_stack srs_chk #(.AW(AW), .CNT_W(CNT_W)) u_srs_chk (
  .clk(clk), .rst_n(rst_n), .call_valid(call_valid), .ret_valid(ret_valid),
  .ret_addr(ret_addr), .ret_ready(ret_ready), .ret_target(ret_target),
  .viol_pulse(viol_pulse), .under_pulse(under_pulse), .viol_count(viol_count),
  .spill_wr_en(spill_wr_en), .spill_rd_req(spill_rd_req)
);

// File: tb/shadow_ret_stack_test.sv
module shadow_ret_stack_test;
  localparam int PERIOD = 10;
  localparam int AW = 32;
  localparam int DEPTH = 16;
  localparam int CNT_W = 3;
  localparam int SPILL_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic call_valid = 1'b0, ret_valid = 1'b0;
  logic [AW-1:0] call_addr = '0, ret_addr = '0;
  logic ret_ready, viol_pulse, under_pulse, spill_wr_en, spill_rd_req;
  logic [AW-1:0] ret_target, spill_wr_data;
  logic [CNT_W-1:0] viol_count;
  logic [SPILL_W-1:0] spill_addr;
  logic spill_rd_valid = 1'b0;
  logic [AW-1:0] spill_rd_data = '0;

  int total = 0, bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  shadow_ret_stack #(.AW(AW), .DEPTH(DEPTH), .CNT_W(CNT_W), .SPILL_W(SPILL_W)) uut (
    .clk(clk), .rst_n(rst_n), .call_valid(call_valid), .call_addr(call_addr),
    .ret_valid(ret_valid), .ret_addr(ret_addr), .ret_ready(ret_ready),
    .ret_target(ret_target), .viol_pulse(viol_pulse), .under_pulse(under_pulse),
    .viol_count(viol_count), .spill_wr_en(spill_wr_en), .spill_rd_req(spill_rd_req),
    .spill_addr(spill_addr), .spill_wr_data(spill_wr_data),
    .spill_rd_valid(spill_rd_valid), .spill_rd_data(spill_rd_data)
  );

  // overflow region model: answers a read two edges after the request
  logic [AW-1:0] smem [64];
  int pend = 0;
  logic [5:0] pend_addr = '0;
  always @(posedge clk) begin
    spill_rd_valid <= 1'b0;
    if (spill_wr_en) smem[spill_addr[5:0]] <= spill_wr_data;
    if (spill_rd_req) begin
      pend <= 2;
      pend_addr <= spill_addr[5:0];
    end else if (pend == 1) begin
      spill_rd_valid <= 1'b1;
      spill_rd_data <= smem[pend_addr];
      pend <= 0;
    end else if (pend != 0) begin
      pend <= pend - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_call(input logic [AW-1:0] a, input bit exp_spill,
                         input logic [AW-1:0] exp_data, input int exp_idx);
    @(negedge clk);
    ret_valid = 1'b0;
    call_valid = 1'b1;
    call_addr = a;
    #1;
    chk(spill_wr_en == exp_spill, "R6 spill_wr_en", AW'(spill_wr_en), AW'(exp_spill));
    if (exp_spill) begin
      chk(spill_wr_data == exp_data, "R6 spill data", spill_wr_data, exp_data);
      chk(spill_addr == SPILL_W'(exp_idx), "R6 spill index", AW'(spill_addr), AW'(exp_idx));
    end
    @(negedge clk);
    call_valid = 1'b0;
  endtask

  task automatic do_ret(input logic [AW-1:0] a, input logic [AW-1:0] exp_t,
                        input bit exp_stall, input int exp_idx,
                        input bit exp_viol, input bit exp_under, input int exp_cnt);
    bit first_ready, first_req;
    logic [SPILL_W-1:0] first_addr;
    int n = 0;
    @(negedge clk);
    call_valid = 1'b0;
    ret_valid = 1'b1;
    ret_addr = a;
    #1;
    first_ready = ret_ready;
    first_req = spill_rd_req;
    first_addr = spill_addr;
    while (!ret_ready && n < 40) begin
      @(negedge clk);
      #1;
      n++;
    end
    chk(first_ready == !exp_stall, "R7 stall", AW'(first_ready), AW'(!exp_stall));
    if (exp_stall) begin
      chk(first_req && first_addr == SPILL_W'(exp_idx), "R7 refill index",
          AW'(first_addr), AW'(exp_idx));
    end
    chk(ret_ready, "R7 accepted", AW'(ret_ready), 1);
    chk(ret_target == exp_t, "R2 ret_target", ret_target, exp_t);
    @(negedge clk);
    ret_valid = 1'b0;
    #1;
    chk(viol_pulse == exp_viol, exp_viol ? "R4 viol_pulse" : "R3 no viol_pulse",
        AW'(viol_pulse), AW'(exp_viol));
    chk(under_pulse == exp_under, "R8 under_pulse", AW'(under_pulse), AW'(exp_under));
    chk(viol_count == CNT_W'(exp_cnt), "R4 R5 viol_count", AW'(viol_count), AW'(exp_cnt));
  endtask

  task automatic t_reset();
    #1;
    chk(ret_ready == 1'b1, "R1 ret_ready", AW'(ret_ready), 1);
    chk(ret_target == '0, "R1 ret_target", ret_target, 0);
    chk(!viol_pulse && !under_pulse, "R1 pulses", AW'({viol_pulse, under_pulse}), 0);
    chk(!spill_wr_en && !spill_rd_req, "R1 spill port", AW'({spill_wr_en, spill_rd_req}), 0);
    chk(viol_count == '0, "R1 viol_count", AW'(viol_count), 0);
  endtask

  task automatic t_lifo();
    do_call(32'hA000_0010, 0, 0, 0);
    do_call(32'hA000_0020, 0, 0, 0);
    do_call(32'hA000_0030, 0, 0, 0);
    do_ret(32'hA000_0030, 32'hA000_0030, 0, 0, 0, 0, 0);  // R3
    do_ret(32'hA000_0020, 32'hA000_0020, 0, 0, 0, 0, 0);
    do_ret(32'hA000_0010, 32'hA000_0010, 0, 0, 0, 0, 0);
  endtask

  task automatic t_mismatch();
    do_call(32'h0000_4440, 0, 0, 0);
    do_call(32'h0000_5550, 0, 0, 0);
    // overwritten program-stack value; saved copy must still be supplied (R4)
    do_ret(32'hDEAD_BEEF, 32'h0000_5550, 0, 0, 1, 0, 1);
    @(negedge clk);
    #1;
    chk(viol_pulse == 1'b0, "R4 pulse one cycle", AW'(viol_pulse), 0);
    // ret_addr must not have entered storage (R2)
    do_ret(32'h0000_4440, 32'h0000_4440, 0, 0, 0, 0, 1);
  endtask

  task automatic t_underflow();
    do_ret(32'h0000_0BAD, 32'h0, 0, 0, 0, 1, 1);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    call_valid = 1'b1;
    call_addr = 32'h0000_7770;
    ret_valid = 1'b1;
    ret_addr = 32'h0000_7770;
    #1;
    chk(ret_ready == 1'b0, "R9 call wins", AW'(ret_ready), 0);
    @(negedge clk);
    call_valid = 1'b0;
    ret_valid = 1'b0;
    do_ret(32'h0000_7770, 32'h0000_7770, 0, 0, 0, 0, 1);  // R9 call was taken
  endtask

  task automatic t_spill();
    for (int i = 0; i < DEPTH + 4; i++) begin
      do_call(32'h1000 + 32'(i * 4), i >= DEPTH, 32'h1000 + 32'((i - DEPTH) * 4), i - DEPTH);
    end
    for (int j = DEPTH + 3; j >= 0; j--) begin
      do_ret(32'h1000 + 32'(j * 4), 32'h1000 + 32'(j * 4), j < 4, j, 0, 0, 1);
    end
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 8; k++) do_call(32'h0000_9000 + 32'(k), 0, 0, 0);
    for (int k = 7; k >= 0; k--) begin
      int e = (9 - k) > 7 ? 7 : (9 - k);
      do_ret(32'hFFFF_0000, 32'h0000_9000 + 32'(k), 0, 0, 1, 0, e);  // R5
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_lifo();
    t_mismatch();
    t_underflow();
    t_same_cycle();
    t_spill();
    t_saturate();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule